// File: doc/BRIEF.md
# Interlace Address and Data-Chaining Unit

This block holds the memory address and the remaining word count for one word-oriented I/O channel. A single 24-bit control word loads the low address and low count bits at once, and a separate widening command later supplies the high-order bits of both. Each time the channel moves one memory word, a step strobe advances the address and lowers the count.

Data chaining lets a transfer run on past a page. Software first loads a 6-bit chain register with a target page and an interrupt-arm bit. On the first step whose incremented address lands on a page boundary, the address jumps to the start of the target page instead of the next sequential word. A one-cycle interrupt pulse may be raised at that point. Memory access and character packing sit outside this block.

Top module: `ilc_chain_top`

## Requirements
- R1: After synchronous reset the address, count, interlace-active flag, chain-pending flag and interrupt output are all 0, and count_zero_o is 1.
- R2: A load command takes count bits [9:0] from ctl_word_i[23:14] and address bits [13:0] from ctl_word_i[13:0], leaves address bits [15:14] and count bits [14:10] unchanged, and sets ilc_active_o.
- R3: A widen command replaces address bits [15:14] with ctl_word_i[1:0] and count bits [14:10] with ctl_word_i[6:2], and leaves the low bits of both unchanged.
- R4: A clear command sets both the address and the count to 0.
- R5: A chain command stores ctl_word_i[5] as the interrupt-arm bit and ctl_word_i[4:0] as the target page, and sets chain_pend_o. The pending flag stays set until a chain jump is taken.
- R6: A step with no chain jump sets the address to the old address plus one, wrapping from 16'hFFFF to 0.
- R7: A chain jump happens on a step when chain_pend_o is 1 and bits [10:0] of (address + 1) are 0. The address becomes page << 11 and chain_pend_o clears. If the arm bit is 1, chain_irq_o is high for exactly the one cycle after that step's clock edge.
- R8: Every step lowers the count by one modulo 2^15, so a step at 0 gives 15'h7FFF.
- R9: count_zero_o is 1 exactly when the count is 0.
- R10: When several strobes are high together, only the highest-priority one acts. The order from highest to lowest is clear, load, widen, chain, step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ilc_alert_i | input | 1 | Clear command: zero address and count |
| ilc_load_i | input | 1 | Load low address and count bits from the control word |
| widen_i | input | 1 | Load high address and count bits from the control word |
| chain_load_i | input | 1 | Load the chain register from the control word |
| step_i | input | 1 | One memory word transferred |
| ctl_word_i | input | 24 | Control word shared by all commands |
| addr_o | output | 16 | Current memory address |
| count_o | output | 15 | Current word count |
| count_zero_o | output | 1 | Count equals zero |
| ilc_active_o | output | 1 | Interlace has been loaded |
| chain_pend_o | output | 1 | Chain jump pending |
| chain_irq_o | output | 1 | One-cycle chain interrupt pulse |

## Verification
The assertions assume that the strobes arrive as a one-hot or idle set in nearly every cycle. Where several strobes are high together, they assume the priority decode gives the block one command per cycle, so each property looks at the decoded command rather than at the raw strobes. The directed stimulus drives one strobe per command. The exception is a dedicated priority scenario, which raises pairs of strobes on purpose and compares the outcome with the winner alone. All stimulus changes at the falling edge, so every property samples settled inputs.

// File: rtl/ilc_pkg.sv
package ilc_pkg;

    // Decoded command, one per cycle, chosen by strobe priority
    typedef enum logic [2:0] {
        CMD_IDLE  = 3'd0,
        CMD_CLEAR = 3'd1,
        CMD_LOAD  = 3'd2,
        CMD_WIDEN = 3'd3,
        CMD_CHAIN = 3'd4,
        CMD_STEP  = 3'd5
    } ilc_cmd_e;

endpackage

// File: rtl/ilc_chain_reg.sv
module ilc_chain_reg
    import ilc_pkg::*;
#(
    parameter int PAGE_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  ilc_cmd_e          cmd_i,
    input  logic [PAGE_W:0]   field_i,
    input  logic              take_i,
    output logic              arm_o,
    output logic [PAGE_W-1:0] page_o,
    output logic              pend_o
);

    typedef struct packed {
        logic              arm;
        logic [PAGE_W-1:0] page;
        logic              pend;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_i == CMD_CHAIN) begin
            st_d.arm  = field_i[PAGE_W];
            st_d.page = field_i[PAGE_W-1:0];
            st_d.pend = 1'b1;
        end else if (take_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign arm_o  = st_q.arm;
    assign page_o = st_q.page;
    assign pend_o = st_q.pend;

    AST_CHAIN_SETS_PEND: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_i == CMD_CHAIN |=> pend_o); // R5
    AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_o && cmd_i != CMD_STEP) |=> pend_o); // R5

endmodule

// File: rtl/ilc_addr_reg.sv
module ilc_addr_reg
    import ilc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LOW_W      = 14,
    parameter int PAGE_SHIFT = 11,
    parameter int PAGE_W     = 5
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  ilc_cmd_e                cmd_i,
    input  logic [LOW_W-1:0]        low_i,
    input  logic [ADDR_W-LOW_W-1:0] hi_i,
    input  logic                    pend_i,
    input  logic                    arm_i,
    input  logic [PAGE_W-1:0]       page_i,
    output logic [ADDR_W-1:0]       addr_o,
    output logic                    take_o,
    output logic                    irq_o
);

    localparam int HI_W = ADDR_W - LOW_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              irq;
    } addr_t;

    addr_t             st_d, st_q;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] jump_addr;
    logic              take;

    always_comb begin
        seq_addr  = st_q.addr + 1'b1;
        jump_addr = ADDR_W'(page_i) << PAGE_SHIFT;
        take      = (cmd_i == CMD_STEP) && pend_i &&
                    (seq_addr[PAGE_SHIFT-1:0] == '0);
        st_d      = st_q;
        st_d.irq  = take && arm_i;
        case (cmd_i)
            CMD_CLEAR: st_d.addr = '0;
            CMD_LOAD:  st_d.addr = {st_q.addr[ADDR_W-1:LOW_W], low_i};
            CMD_WIDEN: st_d.addr = {hi_i, st_q.addr[LOW_W-1:0]};
            CMD_STEP:  st_d.addr = take ? jump_addr : seq_addr;
            default:   st_d.addr = st_q.addr;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign addr_o = st_q.addr;
    assign take_o = take;
    assign irq_o  = st_q.irq;

    AST_LOAD_KEEPS_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_i == CMD_LOAD |=> addr_o[ADDR_W-1:LOW_W] == $past(addr_o[ADDR_W-1:LOW_W])); // R2
    AST_WIDEN_KEEPS_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_i == CMD_WIDEN |=> addr_o[LOW_W-1:0] == $past(addr_o[LOW_W-1:0])); // R3
    AST_CLEAR_ADDR: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_i == CMD_CLEAR |=> addr_o == '0); // R4
    AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_i == CMD_STEP && !pend_i) |=> addr_o == $past(addr_o) + 1'b1); // R6
    AST_IRQ_ON_PAGE_START: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> addr_o[PAGE_SHIFT-1:0] == '0); // R7
    AST_IRQ_AFTER_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> $past(cmd_i) == CMD_STEP); // R7
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |=> !irq_o); // R7

endmodule

// File: rtl/ilc_word_count.sv
module ilc_word_count
    import ilc_pkg::*;
#(
    parameter int CNT_W = 15,
    parameter int LOW_W = 10
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  ilc_cmd_e               cmd_i,
    input  logic [LOW_W-1:0]       low_i,
    input  logic [CNT_W-LOW_W-1:0] hi_i,
    output logic [CNT_W-1:0]       count_o,
    output logic                   zero_o,
    output logic                   active_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             active;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (cmd_i)
            CMD_CLEAR: st_d.count = '0;
            CMD_LOAD: begin
                st_d.count  = {st_q.count[CNT_W-1:LOW_W], low_i};
                st_d.active = 1'b1;
            end
            CMD_WIDEN: st_d.count = {hi_i, st_q.count[LOW_W-1:0]};
            CMD_STEP:  st_d.count = st_q.count - 1'b1;
            default:   st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign count_o  = st_q.count;
    assign zero_o   = (st_q.count == '0);
    assign active_o = st_q.active;

    AST_STEP_DECREMENT: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_i == CMD_STEP |=> count_o == $past(count_o) - 1'b1); // R8
    AST_CLEAR_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_i == CMD_CLEAR |=> zero_o); // R4
    AST_LOAD_ACTIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        cmd_i == CMD_LOAD |=> active_o); // R2

endmodule

// File: rtl/ilc_chain_top.sv
module ilc_chain_top
    import ilc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LOW_MA_W   = 14,
    parameter int CNT_W      = 15,
    parameter int LOW_WC_W   = 10,
    parameter int PAGE_SHIFT = 11,
    parameter int PAGE_W     = 5
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic                         ilc_alert_i,
    input  logic                         ilc_load_i,
    input  logic                         widen_i,
    input  logic                         chain_load_i,
    input  logic                         step_i,
    input  logic [LOW_MA_W+LOW_WC_W-1:0] ctl_word_i,
    output logic [ADDR_W-1:0]            addr_o,
    output logic [CNT_W-1:0]             count_o,
    output logic                         count_zero_o,
    output logic                         ilc_active_o,
    output logic                         chain_pend_o,
    output logic                         chain_irq_o
);

    localparam int HI_MA_W = ADDR_W - LOW_MA_W;
    localparam int HI_WC_W = CNT_W - LOW_WC_W;
    localparam int CHAIN_W = PAGE_W + 1;

    ilc_cmd_e          cmd;
    logic              take;
    logic              arm;
    logic [PAGE_W-1:0] page;

    // Priority: clear, load, widen, chain, step (R10)
    always_comb begin
        if      (ilc_alert_i)  cmd = CMD_CLEAR;
        else if (ilc_load_i)   cmd = CMD_LOAD;
        else if (widen_i)      cmd = CMD_WIDEN;
        else if (chain_load_i) cmd = CMD_CHAIN;
        else if (step_i)       cmd = CMD_STEP;
        else                   cmd = CMD_IDLE;
    end

    ilc_chain_reg #(.PAGE_W(PAGE_W)) u_chain (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .cmd_i   (cmd),
        .field_i (ctl_word_i[CHAIN_W-1:0]),
        .take_i  (take),
        .arm_o   (arm),
        .page_o  (page),
        .pend_o  (chain_pend_o)
    );

    ilc_addr_reg #(
        .ADDR_W     (ADDR_W),
        .LOW_W      (LOW_MA_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .PAGE_W     (PAGE_W)
    ) u_addr (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cmd_i  (cmd),
        .low_i  (ctl_word_i[LOW_MA_W-1:0]),
        .hi_i   (ctl_word_i[HI_MA_W-1:0]),
        .pend_i (chain_pend_o),
        .arm_i  (arm),
        .page_i (page),
        .addr_o (addr_o),
        .take_o (take),
        .irq_o  (chain_irq_o)
    );

    ilc_word_count #(
        .CNT_W (CNT_W),
        .LOW_W (LOW_WC_W)
    ) u_count (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .cmd_i    (cmd),
        .low_i    (ctl_word_i[LOW_MA_W +: LOW_WC_W]),
        .hi_i     (ctl_word_i[HI_MA_W +: HI_WC_W]),
        .count_o  (count_o),
        .zero_o   (count_zero_o),
        .active_o (ilc_active_o)
    );

    AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        ilc_alert_i |=> (addr_o == '0 && count_o == '0)); // R10
    AST_JUMP_CLEARS_PEND: assert property (@(posedge clk_i) disable iff (rst_i)
        chain_irq_o |-> !chain_pend_o); // R7

endmodule

// File: tb/test_ilc_chain_top.sv
`timescale 1ns/100ps
module test_ilc_chain_top;

    localparam logic [4:0] S_NONE  = 5'b00000;
    localparam logic [4:0] S_ALERT = 5'b10000;
    localparam logic [4:0] S_LOAD  = 5'b01000;
    localparam logic [4:0] S_WIDEN = 5'b00100;
    localparam logic [4:0] S_CHAIN = 5'b00010;
    localparam logic [4:0] S_STEP  = 5'b00001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  strb = '0;
    logic [23:0] word = '0;
    logic [15:0] addr;
    logic [14:0] count;
    logic        czero, active, pend, irq;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    ilc_chain_top i_ilc_chain_top (
        .clk_i        (clk),
        .rst_i        (rst),
        .ilc_alert_i  (strb[4]),
        .ilc_load_i   (strb[3]),
        .widen_i      (strb[2]),
        .chain_load_i (strb[1]),
        .step_i       (strb[0]),
        .ctl_word_i   (word),
        .addr_o       (addr),
        .count_o      (count),
        .count_zero_o (czero),
        .ilc_active_o (active),
        .chain_pend_o (pend),
        .chain_irq_o  (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [4:0] s, input logic [23:0] w);
        @(negedge clk);
        strb = s;
        word = w;
        @(negedge clk);
        strb = S_NONE;
        word = '0;
    endtask

    function automatic logic [23:0] ilc_word(input logic [9:0] wc, input logic [13:0] ma);
        return {wc, ma};
    endfunction

    task automatic t_reset;
        chk("R1 addr", 32'(addr), 0);
        chk("R1 count", 32'(count), 0);
        chk("R1 zero", 32'(czero), 1);
        chk("R1 active", 32'(active), 0);
        chk("R1 pend", 32'(pend), 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_load_widen;
        apply(S_LOAD, ilc_word(10'h155, 14'h1234));
        chk("R2 addr", 32'(addr), 32'h1234);
        chk("R2 count", 32'(count), 32'h155);
        chk("R2 active", 32'(active), 1);
        apply(S_WIDEN, 24'h00000E);
        chk("R3 addr", 32'(addr), 32'h9234);
        chk("R3 count", 32'(count), 32'hD55);
        apply(S_LOAD, ilc_word(10'h3FF, 14'h0001));
        chk("R2 addr keeps high", 32'(addr), 32'h8001);
        chk("R2 count keeps high", 32'(count), 32'hFFF);
        apply(S_STEP, '0);
        chk("R6 addr", 32'(addr), 32'h8002);
        chk("R8 count", 32'(count), 32'hFFE);
    endtask

    task automatic t_clear_and_underflow;
        apply(S_ALERT, 24'hFFFFFF);
        chk("R4 addr", 32'(addr), 0);
        chk("R4 count", 32'(count), 0);
        chk("R9 zero", 32'(czero), 1);
        apply(S_STEP, '0);
        chk("R8 underflow", 32'(count), 32'h7FFF);
        chk("R9 nonzero", 32'(czero), 0);
        chk("R6 addr", 32'(addr), 1);
    endtask

    task automatic t_armed_chain;
        apply(S_LOAD, ilc_word(10'h002, 14'h07FE));
        chk("R2 addr", 32'(addr), 32'h07FE);
        chk("R2 count", 32'(count), 32'h7C02);
        apply(S_CHAIN, 24'h000023);
        chk("R5 pend", 32'(pend), 1);
        chk("R5 addr unchanged", 32'(addr), 32'h07FE);
        apply(S_STEP, '0);
        chk("R7 no jump mid-page", 32'(addr), 32'h07FF);
        chk("R5 pend held", 32'(pend), 1);
        chk("R7 no irq mid-page", 32'(irq), 0);
        apply(S_STEP, '0);
        chk("R7 jump addr", 32'(addr), 32'h1800);
        chk("R7 irq pulse", 32'(irq), 1);
        chk("R7 pend cleared", 32'(pend), 0);
        chk("R8 count", 32'(count), 32'h7C00);
        apply(S_STEP, '0);
        chk("R7 irq one cycle", 32'(irq), 0);
        chk("R6 after jump", 32'(addr), 32'h1801);
        chk("R8 count", 32'(count), 32'h7BFF);
    endtask

    task automatic t_unarmed_chain;
        apply(S_LOAD, ilc_word(10'h001, 14'h0FFF));
        chk("R2 count", 32'(count), 32'h7801);
        apply(S_CHAIN, 24'h000005);
        apply(S_STEP, '0);
        chk("R7 unarmed jump", 32'(addr), 32'h2800);
        chk("R7 unarmed no irq", 32'(irq), 0);
        chk("R7 unarmed pend cleared", 32'(pend), 0);
    endtask

    task automatic t_count_zero;
        apply(S_ALERT, '0);
        apply(S_LOAD, ilc_word(10'h001, 14'h0000));
        chk("R9 one", 32'(czero), 0);
        apply(S_STEP, '0);
        chk("R8 reach zero", 32'(count), 0);
        chk("R9 zero", 32'(czero), 1);
    endtask

    task automatic t_wrap;
        apply(S_WIDEN, 24'h000003);
        chk("R3 hi addr", 32'(addr), 32'hC001);
        apply(S_LOAD, ilc_word(10'h000, 14'h3FFF));
        chk("R2 top addr", 32'(addr), 32'hFFFF);
        apply(S_STEP, '0);
        chk("R6 wrap", 32'(addr), 0);
        chk("R8 wrap count", 32'(count), 32'h7FFF);
    endtask

    task automatic t_priority;
        apply(S_ALERT | S_LOAD, ilc_word(10'h3FF, 14'h3FFF));
        chk("R10 clear over load addr", 32'(addr), 0);
        chk("R10 clear over load count", 32'(count), 0);
        apply(S_LOAD | S_STEP, ilc_word(10'h005, 14'h0100));
        chk("R10 load over step addr", 32'(addr), 32'h0100);
        chk("R10 load over step count", 32'(count), 5);
        apply(S_WIDEN | S_CHAIN, 24'h000000);
        chk("R10 widen over chain", 32'(pend), 0);
        apply(S_CHAIN | S_STEP, 24'h000021);
        chk("R10 chain over step addr", 32'(addr), 32'h0100);
        chk("R10 chain over step pend", 32'(pend), 1);
        chk("R10 chain over step count", 32'(count), 5);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load_widen();
        t_clear_and_underflow();
        t_armed_chain();
        t_unarmed_chain();
        t_count_zero();
        t_wrap();
        t_priority();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule